// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a supervisory timer that software must service regularly. A free-running prescaler divides the clock by a power of two chosen by a 3-bit select input. Each time the prescaler completes a period, it advances an 8-bit watchdog counter. If the counter wraps past its top value before the system services it, the block raises a one-cycle reset request. The system-level reset logic consumes that request.

Two status flags are kept next to the counter.

- **Time-out flag:** set by a service (clear) command and dropped by a counter wrap.
- **Power-down flag:** set by a service command and dropped by a sleep command.

A service command restarts both the prescaler and the counter from zero. Pulling the enable low holds both stages at zero and suppresses the reset request.

Top module: `wdt_guard`

## Requirements
- R1: While reset is applied and after it is released, `trip_o` is 0, `tmo_o` is 1 and `pwr_o` is 1.
- R2: A service command (`kick_i` high at a clock edge) returns the prescaler and the counter to zero. The next counter wrap happens exactly 256·2^(sel+1) enabled clock edges after the service edge.
- R3: The prescaler divides the clock by 2^(`div_sel_i`+1), so select 0 divides by 2 and select 7 divides by 256. Each completed prescaler period advances the counter by one.
- R4: When the counter wraps from FFh to 00h, `trip_o` is high for exactly one cycle. `tmo_o` reads 0 from that same cycle on.
- R5: A service command sets `tmo_o` and `pwr_o` to 1 from the following cycle.
- R6: A sleep command (`nap_i` high at an edge without `kick_i`) clears `pwr_o` to 0 and leaves the counting undisturbed. `pwr_o` never falls without a sleep command.
- R7: While `en_i` is low, the prescaler and the counter hold at zero and `trip_o` stays 0. When `en_i` rises again, a full wrap period is counted from zero.
- R8: When `kick_i` and `nap_i` are high at the same edge, the service command wins and `pwr_o` reads 1.
- R9: A service command on the edge where the counter would wrap cancels the wrap: `trip_o` stays 0 and `tmo_o` stays 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Watchdog enable; low holds both stages at zero |
| kick_i | input | 1 | Service command; restarts the timing and sets both flags |
| nap_i | input | 1 | Sleep command; clears the power-down flag |
| div_sel_i | input | 3 | Prescale select; division ratio is 2^(value+1) |
| trip_o | output | 1 | One-cycle reset request on counter wrap |
| tmo_o | output | 1 | Time-out flag, 0 after a wrap |
| pwr_o | output | 1 | Power-down flag, 0 after a sleep command |

## Verification
The assertions take two things for granted:

- The command inputs are already synchronous to `clk`.
- A sleep command is the only way the power-down flag is meant to fall.

Given those, they treat every `kick_i` edge as overriding both a wrap and a sleep. The bench drives all inputs on the falling edge, so each command is seen by exactly one rising edge. It also holds `div_sel_i` steady for the whole of each measured period, so the expected wrap time is a single power-of-two product.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

  // Width of the prescale select field.
  localparam int unsigned SEL_W = 3;
  // Width of the watchdog counter.
  localparam int unsigned CNT_W = 8;
  // Prescaler width: large enough for the longest ratio, 2^(2^SEL_W).
  localparam int unsigned PRE_W = 2 ** SEL_W;

  typedef struct packed {
    logic trip;
    logic tmo;
    logic pwr;
  } wdt_flags_t;

  localparam wdt_flags_t FLAGS_RST = '{trip: 1'b0, tmo: 1'b1, pwr: 1'b1};

endpackage

// File: rtl/wdt_rst_sync.sv
module wdt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_guard_pkg::*;
#(
  parameter int unsigned S_W = SEL_W,
  parameter int unsigned P_W = PRE_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           run_i,
  input  logic           clr_i,
  input  logic [S_W-1:0] sel_i,
  output logic           tick_o
);

  logic [P_W-1:0] pre_q;
  logic [P_W-1:0] pre_d;
  logic [P_W-1:0] lim;
  logic           at_lim;

  // Terminal value 2^(sel+1)-1: bit i is set when i <= sel.
  for (genvar i = 0; i < P_W; i++) begin : g_lim
    localparam logic [S_W-1:0] IDX = S_W'(i);
    assign lim[i] = (IDX <= sel_i);
  end

  // ">=" lets a select lowered mid-period end that period at once.
  assign at_lim = (pre_q >= lim);
  assign tick_o = run_i && !clr_i && at_lim;

  always_comb begin
    if (!run_i || clr_i) pre_d = '0;
    else if (at_lim)     pre_d = '0;
    else                 pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_guard_pkg::*;
#(
  parameter int unsigned C_W = CNT_W
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic tick_i,
  output logic wrap_o
);

  localparam logic [C_W-1:0] TOP = '1;

  logic [C_W-1:0] cnt_q;
  logic [C_W-1:0] cnt_d;
  logic           cnt_en;

  // The counter only changes when it is cleared or advanced.
  assign cnt_en = !run_i || clr_i || tick_i;
  assign wrap_o = run_i && !clr_i && tick_i && (cnt_q == TOP);

  always_comb begin
    if (!run_i || clr_i) cnt_d = '0;
    else                 cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

endmodule

// File: rtl/wdt_status.sv
module wdt_status
  import wdt_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       nap_i,
  input  logic       wrap_i,
  output wdt_flags_t flags_o
);

  wdt_flags_t fl_q;
  wdt_flags_t fl_d;

  always_comb begin
    fl_d      = fl_q;
    fl_d.trip = wrap_i;
    // A service command has priority over both a wrap and a sleep.
    if (clr_i) begin
      fl_d.tmo = 1'b1;
      fl_d.pwr = 1'b1;
    end else begin
      if (wrap_i) fl_d.tmo = 1'b0;
      if (nap_i)  fl_d.pwr = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fl_q <= FLAGS_RST;
    else        fl_q <= fl_d;
  end

  assign flags_o = fl_q;

endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
  import wdt_guard_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             kick_i,
  input  logic             nap_i,
  input  logic [SEL_W-1:0] div_sel_i,
  output logic             trip_o,
  output logic             tmo_o,
  output logic             pwr_o
);

  logic       rst_s_n;
  logic       tick;
  logic       wrap;
  wdt_flags_t flags;

  wdt_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_s_n)
  );

  wdt_prescaler #(.S_W(SEL_W), .P_W(PRE_W)) u_pre (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run_i (en_i),
    .clr_i (kick_i),
    .sel_i (div_sel_i),
    .tick_o(tick)
  );

  wdt_counter #(.C_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_s_n),
    .run_i (en_i),
    .clr_i (kick_i),
    .tick_i(tick),
    .wrap_o(wrap)
  );

  wdt_status u_stat (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .clr_i  (kick_i),
    .nap_i  (nap_i),
    .wrap_i (wrap),
    .flags_o(flags)
  );

  assign trip_o = flags.trip;
  assign tmo_o  = flags.tmo;
  assign pwr_o  = flags.pwr;

endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic kick_i,
  input logic nap_i,
  input logic trip_o,
  input logic tmo_o,
  input logic pwr_o
);

  assert_trip_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |=> !trip_o);

  assert_trip_tmo_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trip_o |-> !tmo_o);

  assert_kick_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (tmo_o && pwr_o));

  assert_nap_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (nap_i && !kick_i) |=> !pwr_o);

  assert_pwr_falls_on_nap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_o) |-> $past(nap_i));

  assert_off_no_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !trip_o);

  assert_kick_no_trip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !trip_o);

endmodule

bind wdt_guard wdt_guard_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en_i  (en_i),
  .kick_i(kick_i),
  .nap_i (nap_i),
  .trip_o(trip_o),
  .tmo_o (tmo_o),
  .pwr_o (pwr_o)
);

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;

  logic       clk;
  logic       rst_n;
  logic       en_i;
  logic       kick_i;
  logic       nap_i;
  logic [2:0] div_sel_i;
  logic       trip_o;
  logic       tmo_o;
  logic       pwr_o;

  int n_chk;
  int n_fail;

  wdt_guard dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .kick_i   (kick_i),
    .nap_i    (nap_i),
    .div_sel_i(div_sel_i),
    .trip_o   (trip_o),
    .tmo_o    (tmo_o),
    .pwr_o    (pwr_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Pulse the service command for one edge; returns at the negedge after it.
  task automatic kick();
    @(negedge clk);
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
  endtask

  // Count edges until trip_o is seen high at a negedge.
  task automatic wait_trip(input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!trip_o && n < limit);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n;
    int seen;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    en_i = 1'b0;
    kick_i = 1'b0;
    nap_i = 1'b0;
    div_sel_i = 3'd0;

    // R1 reset state, during and after reset
    repeat (3) @(negedge clk);
    check("R1 trip in reset", int'(trip_o), 0);
    check("R1 tmo in reset", int'(tmo_o), 1);
    check("R1 pwr in reset", int'(pwr_o), 1);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 trip after reset", int'(trip_o), 0);
    check("R1 tmo after reset", int'(tmo_o), 1);
    check("R1 pwr after reset", int'(pwr_o), 1);

    // R7 disabled: no trip over a long window
    seen = 0;
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      if (trip_o) seen++;
    end
    check("R7 no trip while disabled", seen, 0);

    // R2/R3/R4 sweep over every select value
    en_i = 1'b1;
    for (int s = 0; s < 8; s++) begin
      div_sel_i = 3'(s);
      kick();
      check("R5 tmo after kick", int'(tmo_o), 1);
      wait_trip(256 * (2 << s) + 8, n);
      check($sformatf("R2 R3 wrap period sel=%0d", s), n, 256 * (2 << s));
      check("R4 tmo low with trip", int'(tmo_o), 0);
      @(negedge clk);
      check("R4 trip lasts one cycle", int'(trip_o), 0);
    end

    // R6 sleep clears pwr, timing unchanged; R5 kick sets pwr back
    div_sel_i = 3'd0;
    kick();
    for (int i = 0; i < 9; i++) @(negedge clk);
    nap_i = 1'b1;
    @(negedge clk);
    nap_i = 1'b0;
    check("R6 pwr after sleep", int'(pwr_o), 0);
    wait_trip(600, n);
    check("R6 period unchanged by sleep", n + 10, 512);
    check("R6 pwr still low", int'(pwr_o), 0);
    kick();
    check("R5 pwr after kick", int'(pwr_o), 1);
    check("R5 tmo after kick post-trip", int'(tmo_o), 1);

    // R8 kick and sleep together
    @(negedge clk);
    kick_i = 1'b1;
    nap_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
    nap_i = 1'b0;
    check("R8 pwr kick beats sleep", int'(pwr_o), 1);

    // R9 kick on the wrap edge
    kick();
    for (int i = 0; i < 511; i++) @(negedge clk);
    kick_i = 1'b1;
    @(negedge clk);
    kick_i = 1'b0;
    check("R9 no trip on kicked wrap", int'(trip_o), 0);
    check("R9 tmo kept", int'(tmo_o), 1);
    wait_trip(600, n);
    check("R9 full period after kick", n, 512);

    // R7 mid-run disable then re-enable counts from zero
    kick();
    for (int i = 0; i < 300; i++) @(negedge clk);
    en_i = 1'b0;
    seen = 0;
    for (int i = 0; i < 700; i++) begin
      @(negedge clk);
      if (trip_o) seen++;
    end
    check("R7 no trip after disable", seen, 0);
    en_i = 1'b1;
    wait_trip(600, n);
    check("R7 full period after re-enable", n, 512);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule